// File: doc/BRIEF.md
# Hardware Cursor Overlay Engine

This block lays a small two-bit-per-pixel cursor picture over a stream of display pixels, right before the colour stage. It holds the cursor picture in a 1024-byte store. A processor loads and inspects that store through an indexed port that runs on the pixel clock. On every pixel clock the block takes the current beam column and row and the programmed cursor origin. From these it decides whether the beam is inside the cursor. It then emits the two-bit cursor code and a hit flag one clock later. The incoming pixel word and sync bits are delayed by the same clock, so they stay aligned with the code.

The store can be read as one 64x64 picture or as four separate 32x32 pictures, one of which is picked by a slot field. Each byte carries four pixels. A control bit chooses whether the leftmost pixel of a byte sits in the low or the high bit pair. The store has a single read port shared by the display fetch and processor reads. A processor read borrows that port for one clock, and the display repeats its previous code on that clock. Processor writes use their own path and never touch the displayed picture.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is held, cursCode, cursHit, cpuRdValid, cpuRdData, pixOut and syncOut are all zero.
- R2: With cfgMode equal to 00 the cursor is off: cursHit is 0 and cursCode is 00 for every beam position. Any other cfgMode value turns the cursor on.
- R3: A pixel is a hit when 0 <= beamX - cursX < D and 0 <= beamY - cursY < D, where D is 64 when cfgSize64 is 1 and 32 when it is 0. For every other pixel the outputs are cursHit = 0 and cursCode = 00.
- R4: In 64x64 size, cursor pixel (column c, row r) is read from the byte at index 0x100 + 16*r + c/4.
- R5: In 32x32 size, cursor pixel (c, r) is read from the byte at index 0x100 + 0x100*cfgSlot + 8*r + c/4.
- R6: In 64x64 size, cfgSlot has no effect on the displayed codes.
- R7: Let p = c mod 4. With cfgOrderMsb = 0 the pixel is held in byte bits [2p+1:2p]. With cfgOrderMsb = 1 it is held in bits [7-2p:6-2p].
- R8: cursCode and cursHit appear one clock after the beam coordinates that produced them. pixOut and syncOut equal pixIn and syncIn from one clock earlier.
- R9: A write with cpuWrEn at an index from 0x100 to 0x4FF stores cpuWrData in that byte. On that clock the display output is the same as it would be without the write.
- R10: A read with cpuRdEn at an index from 0x100 to 0x4FF returns the stored byte on cpuRdData, with cpuRdValid = 1, one clock later. On that same later clock, cursCode and cursHit repeat their values from the previous clock.
- R11: Accesses at an index outside 0x100 to 0x4FF have no effect on the store. Such a read returns 0x00 with cpuRdValid = 1 and does not hold the display output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgMode | input | 2 | Cursor mode, 00 = off |
| cfgSize64 | input | 1 | 1 = 64x64 cursor, 0 = 32x32 cursor |
| cfgSlot | input | 2 | Image slot for 32x32 size |
| cfgOrderMsb | input | 1 | 1 = leftmost pixel in the high bit pair of a byte |
| cursX | input | 12 | Cursor origin column |
| cursY | input | 12 | Cursor origin row |
| beamX | input | 12 | Current beam column |
| beamY | input | 12 | Current beam row |
| pixIn | input | 24 | Incoming pixel word |
| syncIn | input | 3 | Incoming sync and blank bits |
| cpuIdx | input | 12 | Processor index address |
| cpuWrEn | input | 1 | Processor write strobe |
| cpuRdEn | input | 1 | Processor read strobe |
| cpuWrData | input | 8 | Processor write byte |
| cpuRdData | output | 8 | Processor read byte |
| cpuRdValid | output | 1 | cpuRdData valid |
| cursCode | output | 2 | Cursor code for the delayed pixel |
| cursHit | output | 1 | Delayed pixel lies inside the cursor |
| pixOut | output | 24 | Pixel word delayed by one clock |
| syncOut | output | 3 | Sync bits delayed by one clock |

## Verification
A processor read and a display fetch of a cursor pixel can fall on the same clock, because both need the single read port of the store. The bench first places the beam on a cursor pixel whose code is known to be non-zero. On the next clock it moves the beam outside the cursor and issues a read at the same time. The read counts as correct only if the returned byte matches the model of the store and the display output repeats the earlier non-zero code instead of going to zero. A following clock must then show the fresh miss. A write issued while a cursor pixel is displayed, and a read at an index outside the store, are checked in the same way to confirm that neither one holds or changes the display output.

// File: rtl/cursor_overlay_pkg.sv
package cursor_overlay_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic displayHit;  // beam inside an enabled cursor this cycle
    logic portToCpu;   // read port lent to an in-range processor read
    logic cpuRdAck;    // a processor read was requested this cycle
    logic cpuWrTake;   // in-range processor write this cycle
  } curStrobe_t;

endpackage

// File: rtl/cursor_ctrl.sv
module cursor_ctrl
  import cursor_overlay_pkg::*;
#(
  parameter int COORD_W     = 12,
  parameter int IDX_W       = 12,
  parameter int BIG_DIM     = 64,
  parameter int SMALL_DIM   = 32,
  parameter int ARRAY_BYTES = 1024,
  parameter int IDX_BASE    = 256,
  localparam int OFF_W      = $clog2(BIG_DIM),
  localparam int ADDR_W     = $clog2(ARRAY_BYTES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         cfgMode,
  input  logic               cfgSize64,
  input  logic [COORD_W-1:0] cursX,
  input  logic [COORD_W-1:0] cursY,
  input  logic [COORD_W-1:0] beamX,
  input  logic [COORD_W-1:0] beamY,
  input  logic [IDX_W-1:0]   cpuIdx,
  input  logic               cpuWrEn,
  input  logic               cpuRdEn,
  output curStrobe_t         strobe,
  output logic [OFF_W-1:0]   offX,
  output logic [OFF_W-1:0]   offY,
  output logic [ADDR_W-1:0]  cpuAddr
);

  localparam logic [IDX_W-1:0]   IDX_LO  = IDX_W'(IDX_BASE);
  localparam logic [IDX_W-1:0]   IDX_HI  = IDX_W'(IDX_BASE + ARRAY_BYTES - 1);
  localparam logic [COORD_W-1:0] DIM_BIG = COORD_W'(BIG_DIM);
  localparam logic [COORD_W-1:0] DIM_SML = COORD_W'(SMALL_DIM);

  logic [COORD_W:0]   diffX, diffY;
  logic [COORD_W-1:0] curDim;
  logic               inX, inY, modeOn, cpuInRange;

  // Extra top bit of each difference is the borrow: beam left of / above origin.
  assign diffX  = {1'b0, beamX} - {1'b0, cursX};
  assign diffY  = {1'b0, beamY} - {1'b0, cursY};
  assign curDim = cfgSize64 ? DIM_BIG : DIM_SML;
  assign inX    = !diffX[COORD_W] && (diffX[COORD_W-1:0] < curDim);
  assign inY    = !diffY[COORD_W] && (diffY[COORD_W-1:0] < curDim);
  assign modeOn = |cfgMode;

  assign offX = diffX[OFF_W-1:0];
  assign offY = diffY[OFF_W-1:0];

  assign cpuInRange = (cpuIdx >= IDX_LO) && (cpuIdx <= IDX_HI);
  assign cpuAddr    = ADDR_W'(cpuIdx - IDX_LO);

  always_comb begin
    strobe            = '0;
    strobe.displayHit = modeOn && inX && inY;
    strobe.portToCpu  = cpuRdEn && cpuInRange;
    strobe.cpuRdAck   = cpuRdEn;
    strobe.cpuWrTake  = cpuWrEn && cpuInRange;
  end

  // R3: a hit never lies left of or above the cursor origin.
  p_hit_not_before_origin_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.displayHit |-> (beamX >= cursX) && (beamY >= cursY));

  // R11: the store is only written for indices inside its window.
  p_write_in_window_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cpuWrTake |-> (cpuIdx >= IDX_LO) && (cpuIdx <= IDX_HI) && cpuWrEn);

endmodule

// File: rtl/cursor_data.sv
module cursor_data
  import cursor_overlay_pkg::*;
#(
  parameter int ARRAY_BYTES = 1024,
  parameter int BIG_DIM     = 64,
  parameter int PIX_W       = 24,
  parameter int SYNC_W      = 3,
  localparam int OFF_W      = $clog2(BIG_DIM),
  localparam int ADDR_W     = $clog2(ARRAY_BYTES),
  localparam int LANES      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  curStrobe_t        strobe,
  input  logic              cfgSize64,
  input  logic [1:0]        cfgSlot,
  input  logic              cfgOrderMsb,
  input  logic [OFF_W-1:0]  offX,
  input  logic [OFF_W-1:0]  offY,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [7:0]        cpuWrData,
  input  logic [PIX_W-1:0]  pixIn,
  input  logic [SYNC_W-1:0] syncIn,
  output logic [7:0]        cpuRdData,
  output logic              cpuRdValid,
  output logic [1:0]        cursCode,
  output logic              cursHit,
  output logic [PIX_W-1:0]  pixOut,
  output logic [SYNC_W-1:0] syncOut
);

  logic [7:0]        cells [ARRAY_BYTES];
  logic [ADDR_W-1:0] addrBig, addrSmall, dispAddr, portAddr;
  logic [7:0]        portByte;
  logic [1:0]        laneLsb [LANES];
  logic [1:0]        laneMsb [LANES];
  logic [1:0]        pick;

  // Write path is separate from the read port, so writes never disturb display.
  always_ff @(posedge clk) begin
    if (strobe.cpuWrTake) cells[cpuAddr] <= cpuWrData;
  end

  // Large image: row * 16 + column / 4.  Small image: slot, row * 8 + column / 4.
  assign addrBig   = ADDR_W'({offY, offX[OFF_W-1:2]});
  assign addrSmall = ADDR_W'({cfgSlot, offY[OFF_W-2:0], offX[OFF_W-2:2]});
  assign dispAddr  = cfgSize64 ? addrBig : addrSmall;
  assign portAddr  = strobe.portToCpu ? cpuAddr : dispAddr;
  assign portByte  = cells[portAddr];

  for (genvar p = 0; p < LANES; p++) begin : g_lane
    assign laneLsb[p] = portByte[2*p+1 : 2*p];
    assign laneMsb[p] = portByte[7-2*p : 6-2*p];
  end

  assign pick = cfgOrderMsb ? laneMsb[offX[1:0]] : laneLsb[offX[1:0]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cursCode   <= 2'b00;
      cursHit    <= 1'b0;
      pixOut     <= '0;
      syncOut    <= '0;
      cpuRdData  <= 8'h00;
      cpuRdValid <= 1'b0;
    end else begin
      pixOut     <= pixIn;
      syncOut    <= syncIn;
      cpuRdValid <= strobe.cpuRdAck;
      if (strobe.cpuRdAck) cpuRdData <= strobe.portToCpu ? portByte : 8'h00;
      if (!strobe.portToCpu) begin
        cursHit  <= strobe.displayHit;
        cursCode <= strobe.displayHit ? pick : 2'b00;
      end
    end
  end

  // R10: a borrowed read port holds the display output for one cycle.
  p_read_holds_display_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.portToCpu |=> $stable(cursCode) && $stable(cursHit));

  // R10: every read request is answered on the next cycle.
  p_read_answered_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cpuRdAck |=> cpuRdValid);

  // R3: a miss with the port free yields a cleared code next cycle.
  p_miss_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.displayHit && !strobe.portToCpu) |=> (cursCode == 2'b00) && !cursHit);

  // R8: pixel and sync bits are delayed by exactly one cycle.
  p_pixel_delay_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (pixOut == $past(pixIn)) && (syncOut == $past(syncIn)));

  // R11: a read outside the window returns zero.
  p_outside_read_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cpuRdAck && !strobe.portToCpu) |=> (cpuRdData == 8'h00));

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_overlay_pkg::*;
#(
  parameter int COORD_W     = 12,
  parameter int IDX_W       = 12,
  parameter int BIG_DIM     = 64,
  parameter int SMALL_DIM   = 32,
  parameter int ARRAY_BYTES = 1024,
  parameter int IDX_BASE    = 256,
  parameter int PIX_W       = 24,
  parameter int SYNC_W      = 3,
  localparam int OFF_W      = $clog2(BIG_DIM),
  localparam int ADDR_W     = $clog2(ARRAY_BYTES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         cfgMode,
  input  logic               cfgSize64,
  input  logic [1:0]         cfgSlot,
  input  logic               cfgOrderMsb,
  input  logic [COORD_W-1:0] cursX,
  input  logic [COORD_W-1:0] cursY,
  input  logic [COORD_W-1:0] beamX,
  input  logic [COORD_W-1:0] beamY,
  input  logic [PIX_W-1:0]   pixIn,
  input  logic [SYNC_W-1:0]  syncIn,
  input  logic [IDX_W-1:0]   cpuIdx,
  input  logic               cpuWrEn,
  input  logic               cpuRdEn,
  input  logic [7:0]         cpuWrData,
  output logic [7:0]         cpuRdData,
  output logic               cpuRdValid,
  output logic [1:0]         cursCode,
  output logic               cursHit,
  output logic [PIX_W-1:0]   pixOut,
  output logic [SYNC_W-1:0]  syncOut
);

  curStrobe_t        strobe;
  logic [OFF_W-1:0]  offX, offY;
  logic [ADDR_W-1:0] cpuAddr;

  cursor_ctrl #(
    .COORD_W(COORD_W), .IDX_W(IDX_W), .BIG_DIM(BIG_DIM), .SMALL_DIM(SMALL_DIM),
    .ARRAY_BYTES(ARRAY_BYTES), .IDX_BASE(IDX_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgSize64(cfgSize64),
    .cursX(cursX), .cursY(cursY), .beamX(beamX), .beamY(beamY),
    .cpuIdx(cpuIdx), .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn),
    .strobe(strobe), .offX(offX), .offY(offY), .cpuAddr(cpuAddr)
  );

  cursor_data #(
    .ARRAY_BYTES(ARRAY_BYTES), .BIG_DIM(BIG_DIM), .PIX_W(PIX_W), .SYNC_W(SYNC_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgSize64(cfgSize64),
    .cfgSlot(cfgSlot), .cfgOrderMsb(cfgOrderMsb), .offX(offX), .offY(offY),
    .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .pixIn(pixIn), .syncIn(syncIn),
    .cpuRdData(cpuRdData), .cpuRdValid(cpuRdValid), .cursCode(cursCode),
    .cursHit(cursHit), .pixOut(pixOut), .syncOut(syncOut)
  );

endmodule

// File: tb/cursor_overlay_bench.sv
module cursor_overlay_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  cfgMode;
  logic        cfgSize64;
  logic [1:0]  cfgSlot;
  logic        cfgOrderMsb;
  logic [11:0] cursX, cursY, beamX, beamY;
  logic [23:0] pixIn;
  logic [2:0]  syncIn;
  logic [11:0] cpuIdx;
  logic        cpuWrEn, cpuRdEn;
  logic [7:0]  cpuWrData;
  logic [7:0]  cpuRdData;
  logic        cpuRdValid;
  logic [1:0]  cursCode;
  logic        cursHit;
  logic [23:0] pixOut;
  logic [2:0]  syncOut;

  logic [7:0] shadow [1024];
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cursor_overlay u_cursor_overlay (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgSize64(cfgSize64),
    .cfgSlot(cfgSlot), .cfgOrderMsb(cfgOrderMsb), .cursX(cursX), .cursY(cursY),
    .beamX(beamX), .beamY(beamY), .pixIn(pixIn), .syncIn(syncIn),
    .cpuIdx(cpuIdx), .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn), .cpuWrData(cpuWrData),
    .cpuRdData(cpuRdData), .cpuRdValid(cpuRdValid), .cursCode(cursCode),
    .cursHit(cursHit), .pixOut(pixOut), .syncOut(syncOut)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Expected {hit, code} computed from the requirements.
  function automatic logic [2:0] model(input int bx, input int by);
    int dim, dx, dy, idx, p;
    logic [7:0] b;
    dim = cfgSize64 ? 64 : 32;
    dx = bx - int'(cursX);
    dy = by - int'(cursY);
    if (cfgMode == 2'b00 || dx < 0 || dy < 0 || dx >= dim || dy >= dim) return 3'b000;
    idx = cfgSize64 ? (dy * 16 + dx / 4) : (int'(cfgSlot) * 256 + dy * 8 + dx / 4);
    p = dx % 4;
    b = shadow[idx];
    return {1'b1, cfgOrderMsb ? b[7-2*p -: 2] : b[2*p+1 -: 2]};
  endfunction

  task automatic probe(input int bx, input int by, input string req);
    logic [2:0] exp;
    logic [23:0] pv;
    beamX = 12'(bx);
    beamY = 12'(by);
    pv = 24'(bx * 4099 + by * 17);
    pixIn = pv;
    syncIn = 3'(bx + by);
    exp = model(bx, by);
    step();
    check(cursHit == exp[2], req, "hit", int'(cursHit), int'(exp[2]));
    check(cursCode == exp[1:0], req, "code", int'(cursCode), int'(exp[1:0]));
    check(pixOut == pv, "R8", "pixel delay", int'(pixOut), int'(pv));
  endtask

  task automatic writeByte(input int idx, input logic [7:0] d);
    cpuIdx = 12'(idx);
    cpuWrData = d;
    cpuWrEn = 1'b1;
    step();
    cpuWrEn = 1'b0;
    if (idx >= 256 && idx <= 1279) shadow[idx - 256] = d;
  endtask

  task automatic readByte(input int idx, input string req);
    logic [7:0] exp;
    exp = (idx >= 256 && idx <= 1279) ? shadow[idx - 256] : 8'h00;
    cpuIdx = 12'(idx);
    cpuRdEn = 1'b1;
    step();
    cpuRdEn = 1'b0;
    check(cpuRdValid == 1'b1, req, "read valid", int'(cpuRdValid), 1);
    check(cpuRdData == exp, req, "read data", int'(cpuRdData), int'(exp));
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    cfgMode = 2'b00; cfgSize64 = 1'b0; cfgSlot = 2'b00; cfgOrderMsb = 1'b0;
    cursX = '0; cursY = '0; beamX = '0; beamY = '0;
    pixIn = 24'hABCDEF; syncIn = 3'b111;
    cpuIdx = '0; cpuWrEn = 1'b0; cpuRdEn = 1'b0; cpuWrData = '0;
    repeat (3) step();
    check(cursCode == 0 && cursHit == 0, "R1", "cursor outputs in reset",
          int'({cursHit, cursCode}), 0);
    check(pixOut == 0 && syncOut == 0, "R1", "pixel outputs in reset",
          int'(pixOut), 0);
    check(cpuRdValid == 0 && cpuRdData == 0, "R1", "read outputs in reset",
          int'({cpuRdValid, cpuRdData}), 0);
    rstN = 1'b1;
    step();
  endtask

  task automatic t_fill_and_read();
    for (int i = 0; i < 1024; i++) writeByte(256 + i, 8'((i * 73 + 29) ^ (i >> 3)));
    readByte(256, "R9");
    readByte(256 + 511, "R9");
    readByte(1279, "R10");
  endtask

  task automatic t_mode_off();
    cfgMode = 2'b00; cfgSize64 = 1'b1; cursX = 12'd100; cursY = 12'd50;
    probe(101, 51, "R2");
    probe(120, 60, "R2");
    cfgMode = 2'b10;
    probe(101, 51, "R2");
  endtask

  task automatic t_big();
    cfgMode = 2'b01; cfgSize64 = 1'b1; cfgOrderMsb = 1'b0; cursX = 12'd100; cursY = 12'd50;
    probe(100, 50, "R4");
    probe(163, 113, "R3");
    probe(164, 50, "R3");
    probe(99, 50, "R3");
    probe(100, 114, "R3");
    probe(100, 49, "R3");
    for (int c = 0; c < 8; c++) probe(100 + c * 7, 50 + c * 9, "R4");
  endtask

  task automatic t_small_slots();
    cfgMode = 2'b11; cfgSize64 = 1'b0; cfgOrderMsb = 1'b0; cursX = 12'd7; cursY = 12'd3;
    for (int s = 0; s < 4; s++) begin
      cfgSlot = 2'(s);
      probe(7, 3, "R5");
      probe(38, 34, "R5");
      probe(20, 17, "R5");
      probe(39, 10, "R3");
    end
  endtask

  task automatic t_slot_ignored();
    cfgMode = 2'b01; cfgSize64 = 1'b1; cursX = 12'd0; cursY = 12'd0;
    for (int s = 0; s < 4; s++) begin
      cfgSlot = 2'(s);
      probe(45, 40, "R6");
      probe(13, 2, "R6");
    end
  endtask

  task automatic t_order();
    cfgMode = 2'b01; cfgSize64 = 1'b1; cursX = 12'd200; cursY = 12'd10;
    for (int o = 0; o < 2; o++) begin
      cfgOrderMsb = 1'(o);
      for (int p = 0; p < 4; p++) probe(200 + 20 + p, 15, "R7");
    end
    cfgOrderMsb = 1'b0;
  endtask

  // Display fetch and processor read on the same cycle.
  task automatic t_collide(input int idx, input bit held, input string req);
    int ac;
    logic [2:0] ea;
    logic [7:0] er;
    cfgMode = 2'b01; cfgSize64 = 1'b1; cfgOrderMsb = 1'b0; cursX = 12'd100; cursY = 12'd50;
    ac = 100;
    for (int c = 0; c < 64; c++) begin
      if (model(100 + c, 53) == 3'b100 || model(100 + c, 53) == 3'b000) continue;
      ac = 100 + c;
      break;
    end
    ea = model(ac, 53);
    probe(ac, 53, req);
    er = (idx >= 256 && idx <= 1279) ? shadow[idx - 256] : 8'h00;
    beamX = 12'd0; beamY = 12'd0;
    cpuIdx = 12'(idx);
    cpuRdEn = 1'b1;
    step();
    cpuRdEn = 1'b0;
    check(cpuRdData == er && cpuRdValid, req, "collision read data",
          int'(cpuRdData), int'(er));
    if (held)
      check(cursHit == ea[2] && cursCode == ea[1:0], req, "display held on read",
            int'({cursHit, cursCode}), int'(ea));
    else
      check(cursHit == 0 && cursCode == 0, req, "display not held",
            int'({cursHit, cursCode}), 0);
    step();
    check(cursHit == 0 && cursCode == 0, req, "display recovers",
          int'({cursHit, cursCode}), 0);
  endtask

  task automatic t_write_during_display();
    logic [2:0] ea;
    cfgMode = 2'b01; cfgSize64 = 1'b1; cfgOrderMsb = 1'b0; cursX = 12'd100; cursY = 12'd50;
    beamX = 12'd101; beamY = 12'd50;
    ea = model(101, 50);
    cpuIdx = 12'(256 + 500);
    cpuWrData = ~shadow[500];
    cpuWrEn = 1'b1;
    step();
    cpuWrEn = 1'b0;
    shadow[500] = cpuWrData;
    check(cursHit == ea[2] && cursCode == ea[1:0], "R9", "display during write",
          int'({cursHit, cursCode}), int'(ea));
    for (int p = 0; p < 4; p++) probe(100 + 16 + p, 50 + 31, "R9");
    readByte(256 + 500, "R9");
  endtask

  task automatic t_outside();
    logic [7:0] lo, hi;
    lo = shadow[0];
    hi = shadow[1023];
    writeByte(255, ~lo);
    writeByte(1280, ~hi);
    readByte(255, "R11");
    readByte(1280, "R11");
    readByte(256, "R11");
    readByte(1279, "R11");
    check(shadow[0] == lo && shadow[1023] == hi, "R11", "shadow edges",
          int'(shadow[0]), int'(lo));
    t_collide(80, 1'b0, "R11");
  endtask

  initial begin
    t_reset();
    t_fill_and_read();
    t_mode_off();
    t_big();
    t_small_slots();
    t_slot_ignored();
    t_order();
    t_collide(256 + 37, 1'b1, "R10");
    t_write_during_display();
    t_outside();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule